// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Aggregator

The aggregator folds up to 64 interrupt requests onto one CPU interrupt line. The first level is a 32-bit primary controller. The second level is a 32-bit secondary controller for slow peripherals. The secondary controller summarises its requests into three group bits, and those group bits take three positions in the primary status. Each source is captured in one of two ways. Level sources follow their input wire directly. Edge sources set a sticky latch bit on a rising input, and that bit stays set until software clears it.

Software reaches every mask, latch and status register over a small register bus, and reads return data combinationally in the same cycle. The block also reports the number of the highest-priority pending source. Lower bit numbers have higher priority. A primary source is reported as its 1-based bit number. When the winning primary bit is a group bit, the block reports 32 plus the 1-based number of the winning secondary source.

Top module: `cirq_top`

## Requirements
- R1: Primary status bits 0–3, 7, 8–15, 20, 21, 25–27 and 31 equal the matching `dev_irq_i` bits in the same cycle.
- R2: Primary bits 16–19, 22–24 and 28–30 are sticky latch bits. Each is set in the cycle after a rising edge of its source:
  - bits 16–19 take `dev_irq_i[19:16]`;
  - bits 22–24 take `dev_irq_i[25:27]`;
  - bits 28–30 take bits 0–2 of the software interrupt register.
  The raw `dev_irq_i` bits at positions 4–6, 22–24 and 28–30 have no effect.
- R3: A write to address 2 (primary latch) clears each latch bit whose write-data bit is 0. A written 1 never sets a bit.
- R4: When a rising edge and a clearing write hit the same latch bit in the same cycle, the bit ends up set. This holds for the primary latch and for the secondary latch.
- R5: Each of primary bits 6, 5 and 4 is set when the AND of secondary status and secondary mask is non-zero within that bit's group:
  - bit 6 covers secondary bits 0–7;
  - bit 5 covers secondary bits 8–15;
  - bit 4 covers secondary bits 16–31.
- R6: Secondary bits 16, 22 and 28 are sticky and are set by a rising edge of `periph_irq_i`. A write to address 4 clears each of them whose write-data bit is 0. All other secondary bits follow `periph_irq_i` directly.
- R7: `cpu_irq_o` is 1 exactly when the AND of primary status and primary mask is non-zero.
- R8: `pend_id_o` gives the 1-based index of the lowest set bit in the masked primary status. If that bit is 4, 5 or 6, it gives instead 32 plus the 1-based index of the lowest set bit in the AND of secondary status and secondary mask.
- R9: Reset clears the following to zero: primary mask, primary latch, software register, secondary latch and secondary mask. When nothing masked is pending, `pend_id_o` is 0 and `cpu_irq_o` is 0.
- R10: While `req_valid_i` is high, `rdata_o` returns the addressed register in the same cycle. When `req_valid_i` is low, `rdata_o` is 0.
  - Address 0 is primary status. Writes to it are ignored.
  - Address 1 is primary mask.
  - Address 2 is primary latch.
  - Address 3 is the software register, in bits 2:0.
  - Address 4 is secondary status.
  - Address 5 is secondary mask.
  - Addresses 6 and 7 read 0.
  - A write takes effect at the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_irq_i | input | 32 | Primary-level request inputs |
| periph_irq_i | input | 32 | Secondary-level request inputs |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Register address |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| cpu_irq_o | output | 1 | Combined CPU interrupt |
| pend_id_o | output | 7 | Pending source number (0 = none) |

## Verification
The bench builds the block with the default 32-bit data width and the default edge and group masks from the package. This places every edge-latched bit, every group boundary and the 32-offset secondary numbering at fixed positions that the bench can check. A behavioural reference model runs beside the design and is compared every cycle. The model catches these cases:
- a rising edge that coincides with a clearing write;
- a group bit that is masked out at one level but enabled at the other;
- a priority winner that passes from a primary source to a secondary source.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;
  localparam int unsigned NGRP = 3;
  localparam int unsigned IDW = $clog2(2 * DW) + 1;

  // primary edge bits: 16-19, 22-24, 28-30
  localparam logic [DW-1:0] PRI_EDGE  = 32'h71CF_0000;
  localparam logic [DW-1:0] PRI_GROUP = 32'h0000_0070;
  localparam logic [DW-1:0] PRI_LEVEL = ~(PRI_EDGE | PRI_GROUP);
  localparam int unsigned   GRP_BASE  = 4;
  // secondary edge bits: 16, 22, 28
  localparam logic [DW-1:0] SEC_EDGE  = 32'h1041_0000;
  // groups, index 0 -> primary bit 4
  localparam logic [NGRP*DW-1:0] GRP_MASKS = {32'h0000_00FF, 32'h0000_FF00, 32'hFFFF_0000};

  typedef enum logic [AW-1:0] {
    A_PSTAT  = 3'd0,
    A_PMASK  = 3'd1,
    A_PLATCH = 3'd2,
    A_SOFT   = 3'd3,
    A_SSTAT  = 3'd4,
    A_SMASK  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/cirq_edge_latch.sv
module cirq_edge_latch #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] EDGE_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_keep_i,
  output logic [W-1:0] latch_o
);
  logic [W-1:0] prev_q, latch_q, rise;

  assign rise = src_i & ~prev_q & EDGE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= src_i;
      // a new edge overrides a same-cycle clear
      latch_q <= (latch_q & (clr_en_i ? clr_keep_i : {W{1'b1}})) | rise;
    end
  end

  assign latch_o = latch_q;

  a_r4_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((latch_q & $past(rise)) == $past(rise)));

  a_r3_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((latch_q & ~$past(clr_keep_i) & ~$past(rise)) == '0));
endmodule

// File: rtl/cirq_group_or.sv
module cirq_group_or #(
  parameter int unsigned W = 32,
  parameter int unsigned NG = 3,
  parameter logic [NG*W-1:0] MASKS = '0
) (
  input  logic [W-1:0]  stat_i,
  input  logic [W-1:0]  en_i,
  output logic [NG-1:0] grp_o
);
  logic [W-1:0] act;
  assign act = stat_i & en_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_o[g] = |(act & MASKS[g*W +: W]);
  end
endmodule

// File: rtl/cirq_lowest.sv
module cirq_lowest #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i + 1);
    end
  end
endmodule

// File: rtl/cirq_top.sv
module cirq_top
  import cirq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  dev_irq_i,
  input  logic [DW-1:0]  periph_irq_i,
  input  logic           req_valid_i,
  input  logic           req_write_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           cpu_irq_o,
  output logic [IDW-1:0] pend_id_o
);
  localparam int unsigned LIW = $clog2(DW) + 1;

  logic [DW-1:0]   pmask_q, smask_q;
  logic [2:0]      soft_q;
  logic [DW-1:0]   pedge_src, platch, slatch;
  logic [DW-1:0]   pstat, sstat, pact, sact;
  logic [NGRP-1:0] grp;
  logic [LIW-1:0]  pidx, sidx;
  logic            wr;

  assign wr = req_valid_i & req_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmask_q <= '0;
      smask_q <= '0;
      soft_q  <= '0;
    end else if (wr) begin
      case (req_addr_i)
        A_PMASK: pmask_q <= req_wdata_i;
        A_SMASK: smask_q <= req_wdata_i;
        A_SOFT:  soft_q  <= req_wdata_i[2:0];
        default: ;
      endcase
    end
  end

  // edge sources: 22-24 track level inputs 25-27, 28-30 track the soft register
  always_comb begin
    pedge_src        = dev_irq_i;
    pedge_src[24:22] = dev_irq_i[27:25];
    pedge_src[30:28] = soft_q;
  end

  cirq_edge_latch #(.W(DW), .EDGE_MASK(PRI_EDGE)) i_plat (
    .clk_i, .rst_ni, .src_i(pedge_src),
    .clr_en_i(wr && req_addr_i == A_PLATCH), .clr_keep_i(req_wdata_i),
    .latch_o(platch));

  cirq_edge_latch #(.W(DW), .EDGE_MASK(SEC_EDGE)) i_slat (
    .clk_i, .rst_ni, .src_i(periph_irq_i),
    .clr_en_i(wr && req_addr_i == A_SSTAT), .clr_keep_i(req_wdata_i),
    .latch_o(slatch));

  assign sstat = (periph_irq_i & ~SEC_EDGE) | slatch;
  assign sact  = sstat & smask_q;

  cirq_group_or #(.W(DW), .NG(NGRP), .MASKS(GRP_MASKS)) i_grp (
    .stat_i(sstat), .en_i(smask_q), .grp_o(grp));

  always_comb begin
    pstat = (dev_irq_i & PRI_LEVEL) | platch;
    pstat[GRP_BASE +: NGRP] = grp;
  end

  assign pact      = pstat & pmask_q;
  assign cpu_irq_o = |pact;

  cirq_lowest #(.W(DW)) i_plow (.vec_i(pact), .idx_o(pidx));
  cirq_lowest #(.W(DW)) i_slow (.vec_i(sact), .idx_o(sidx));

  always_comb begin
    if (int'(pidx) > GRP_BASE && int'(pidx) <= GRP_BASE + NGRP)
      pend_id_o = IDW'(DW) + IDW'(sidx);
    else
      pend_id_o = IDW'(pidx);
  end

  always_comb begin
    rdata_o = '0;
    if (req_valid_i) begin
      case (req_addr_i)
        A_PSTAT:  rdata_o = pstat;
        A_PMASK:  rdata_o = pmask_q;
        A_PLATCH: rdata_o = platch;
        A_SOFT:   rdata_o = {{(DW-3){1'b0}}, soft_q};
        A_SSTAT:  rdata_o = sstat;
        A_SMASK:  rdata_o = smask_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_id_o == '0) == !cpu_irq_o);

  a_r8_secondary_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(pend_id_o) > DW) |-> (|(pact[GRP_BASE +: NGRP]) && |sact));

  a_r5_group_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grp) |-> (|sact));

  a_r7_irq_has_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |-> (pend_id_o != '0));
endmodule

// File: tb/test_cirq_top.sv
module test_cirq_top;
  localparam time CLK = 20ns;

  logic        clk = 0, rst_n = 0;
  logic [31:0] dev = 0, per = 0, wdata = 0;
  logic        valid = 0, write = 0;
  logic [2:0]  addr = 0;
  logic [31:0] rdata;
  logic        cpu_irq;
  logic [6:0]  pend;

  int checks = 0, fails = 0;

  always #(CLK/2) clk = ~clk;

  cirq_top i_cirq_top (
    .clk_i(clk), .rst_ni(rst_n), .dev_irq_i(dev), .periph_irq_i(per),
    .req_valid_i(valid), .req_write_i(write), .req_addr_i(addr),
    .req_wdata_i(wdata), .rdata_o(rdata), .cpu_irq_o(cpu_irq), .pend_id_o(pend));

  // ---------------- reference model ----------------
  logic [31:0] m_pmask, m_smask, m_plat, m_slat, m_pprev, m_sprev;
  logic [2:0]  m_soft;

  function automatic bit is_pedge(int b);
    return (b >= 16 && b <= 19) || (b >= 22 && b <= 24) || (b >= 28 && b <= 30);
  endfunction
  function automatic bit is_sedge(int b);
    return b == 16 || b == 22 || b == 28;
  endfunction

  function automatic logic [31:0] m_esrc();
    logic [31:0] s = dev;
    for (int k = 0; k < 3; k++) begin
      s[22+k] = dev[25+k];
      s[28+k] = m_soft[k];
    end
    return s;
  endfunction

  function automatic logic [31:0] m_sstat();
    logic [31:0] s;
    for (int b = 0; b < 32; b++) s[b] = is_sedge(b) ? m_slat[b] : per[b];
    return s;
  endfunction

  function automatic logic [31:0] m_pstat();
    logic [31:0] s, sa;
    sa = m_sstat() & m_smask;
    for (int b = 0; b < 32; b++) s[b] = is_pedge(b) ? m_plat[b] : dev[b];
    s[6] = |sa[7:0];
    s[5] = |sa[15:8];
    s[4] = |sa[31:16];
    return s;
  endfunction

  function automatic int ffs1(logic [31:0] v);
    for (int b = 0; b < 32; b++) if (v[b]) return b + 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pmask = 0; m_smask = 0; m_plat = 0; m_slat = 0;
      m_pprev = 0; m_sprev = 0; m_soft = 0;
    end else begin
      logic [31:0] es, pr, sr;
      es = m_esrc();
      pr = 0; sr = 0;
      for (int b = 0; b < 32; b++) begin
        if (is_pedge(b) && es[b] && !m_pprev[b]) pr[b] = 1;
        if (is_sedge(b) && per[b] && !m_sprev[b]) sr[b] = 1;
      end
      if (valid && write) begin
        case (addr)
          3'd1: m_pmask = wdata;
          3'd2: m_plat  = m_plat & wdata;
          3'd3: m_soft  = wdata[2:0];
          3'd4: m_slat  = m_slat & wdata;
          3'd5: m_smask = wdata;
          default: ;
        endcase
      end
      m_plat  = m_plat | pr;
      m_slat  = m_slat | sr;
      m_pprev = es;
      m_sprev = per;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic [31:0] pa, sa, er;
    int pi, ei;
    pa = m_pstat() & m_pmask;
    sa = m_sstat() & m_smask;
    pi = ffs1(pa);
    ei = (pi >= 5 && pi <= 7) ? 32 + ffs1(sa) : pi;
    check("R7 cpu_irq", {31'b0, cpu_irq}, {31'b0, |pa});
    check("R8 pend_id", {25'b0, pend}, ei);
    case (addr)
      3'd0: er = m_pstat();
      3'd1: er = m_pmask;
      3'd2: er = m_plat;
      3'd3: er = {29'b0, m_soft};
      3'd4: er = m_sstat();
      3'd5: er = m_smask;
      default: er = 0;
    endcase
    if (!valid) er = 0;
    check("R10 rdata", rdata, er);
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    valid = 1; write = 1; addr = a; wdata = d; tick();
    valid = 0; write = 0;
  endtask
  task automatic rd(logic [2:0] a);
    valid = 1; write = 0; addr = a; tick();
    valid = 0;
  endtask

  initial begin
    #(CLK * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK * 3); rst_n = 1; tick();
    // R9: reset values, idle outputs
    for (int a = 0; a < 8; a++) rd(3'(a));
    check("R9 idle cpu_irq", {31'b0, cpu_irq}, 0);
    check("R9 idle pend_id", {25'b0, pend}, 0);

    // R1, R7, R8: level primary sources
    wr(3'd1, 32'hFFFF_FFFF);
    dev = 32'h8000_0000; rd(3'd0);
    dev = 32'h0010_0300; rd(3'd0);
    dev = 32'h0000_0001; tick();
    // R2: raw bits at 4-6, 22-24, 28-30 are ignored
    dev = 32'h71C0_0070; rd(3'd0); rd(3'd2);
    dev = 0; tick();

    // R2: edge bits 16-19 and 22-24 (from 25-27)
    dev = 32'h0005_0000; tick(); dev = 0; rd(3'd2);
    dev = 32'h0A00_0000; tick(); dev = 0; rd(3'd0); rd(3'd2);
    // R3: clear only zero-written bits, ones never set
    wr(3'd2, 32'hFFFB_FFFF); rd(3'd2);
    wr(3'd2, 32'h0000_0000); rd(3'd2);
    // R4: edge beats same-cycle clear
    dev = 32'h0002_0000; wr(3'd2, 32'h0); dev = 0; rd(3'd2);
    wr(3'd2, 0);

    // R2: software interrupts via register
    wr(3'd3, 32'h5); rd(3'd3); rd(3'd2);
    wr(3'd3, 32'h7); rd(3'd2); wr(3'd2, 0); wr(3'd3, 0);

    // R5, R8: groups
    wr(3'd5, 32'h0000_00FF);
    per = 32'h0001_0100; rd(3'd0);   // masked out at secondary
    per = 32'h0000_0008; rd(3'd0);   // audio group -> bit 6
    wr(3'd5, 32'hFFFF_FFFF);
    per = 32'h8000_0200; rd(3'd0);   // misc + serial
    wr(3'd1, 32'h0000_0070); rd(3'd4);
    wr(3'd1, 32'hFFFF_FFFF); per = 0; tick();

    // R6: secondary edges and clear, R4 on secondary
    per = 32'h1041_0000; tick(); per = 0; rd(3'd4);
    wr(3'd4, 32'hFFBF_FFFF); rd(3'd4);
    per = 32'h0001_0000; wr(3'd4, 0); per = 0; rd(3'd4);
    wr(3'd4, 0);

    // mixed random phase covering all requirements
    for (int i = 0; i < 3000; i++) begin
      dev = $urandom() & $urandom();
      per = $urandom() & $urandom();
      valid = ($urandom_range(0, 1) == 1);
      write = ($urandom_range(0, 2) == 0);
      addr = 3'($urandom_range(0, 7));
      wdata = $urandom();
      tick();
    end
    valid = 0; write = 0; tick(); tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule